// File: doc/BRIEF.md
# Lockable Software Reset Bank

This block holds a bank of active-low reset hold lines, one per target module. Software drives each line through its own control register. A control value of 0 keeps the target in reset and a value of 1 lets it run. After the block's own reset, every target runs and every line can be changed.

Each control has a private lock register. Software can clear a lock bit but can never set it again. Once a lock is clear, its control value is frozen until the next block reset. A line that was locked while holding its target in reset therefore keeps that target in reset.

All registers share one word-addressed port with a write strobe and a read data output. Words 0 to NUM_LINES-1 are the lock registers, and words NUM_LINES to 2*NUM_LINES-1 are the control registers. Each register uses bit 0 only. Synchronising the outputs into each target's clock domain is the job of the receiving logic.

Top module: `swrst_bank`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every lock bit reads 1, every control bit reads 1 and every `rst_hold_no` bit is 1.
- R2: Bit i of `rst_hold_no` always equals control bit i. A write of 0 to an unlocked control word N+i drives bit i low from the next cycle on, and the other lines do not change.
- R3: A write of 1 to an unlocked control word returns its line to 1 from the next cycle on.
- R4: A write whose bit 0 is 0 to lock word i clears lock bit i from the next cycle on.
- R5: A write whose bit 0 is 1 to a lock word has no effect. A cleared lock bit stays 0 until block reset.
- R6: While lock bit i is 0, writes to control word N+i leave control bit i and line i unchanged, whether the line is high or low.
- R7: Read data returns the addressed bit in bit 0 and zeros in all other bits. The value is combinational from `addr_i` in the default configuration. Only bit 0 of the write data is used.
- R8: Writes to words at or above 2*NUM_LINES change nothing, and reads from those words return 0.
- R9: Locks are independent. Clearing lock i does not stop writes to any other control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| addr_i | input | ADDR_W | Word address for both reads and writes |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| wr_data_i | input | DATA_W | Write data; only bit 0 is used |
| rd_data_o | output | DATA_W | Read data for the addressed word |
| rst_hold_no | output | NUM_LINES | Reset hold lines; 0 holds the target in reset |

## Verification
On every cycle, the assertions check three things: a lock bit never rises after reset, a control behind a cleared lock stays stable, and accepted writes land in the next cycle. They also check that the upper read bits and unmapped reads are zero.

The bench's scenarios are needed for the rest. They show that the address map places locks and controls at the right indices, that a write of 1 to a lock is ignored, and that a line locked while low stays in reset. They also show that locking one line leaves the others writable. A behavioural model compares every line and every read word on each clock, through both directed and random traffic.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

   typedef enum logic [1:0] {
      REG_LOCK = 2'd0,
      REG_CTRL = 2'd1,
      REG_NONE = 2'd2
   } region_e;

   // Classify a word address against a bank of n lines.
   function automatic region_e region_of(input int unsigned a, input int unsigned n);
      if (a < n)     return REG_LOCK;
      if (a < 2 * n) return REG_CTRL;
      return REG_NONE;
   endfunction

endpackage

// File: rtl/swrst_lock_cell.sv
module swrst_lock_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_hit_i,
   input  logic wr_bit_i,
   output logic lock_o
);

   logic lock_q;

   // Clear-only: software may drop the lock, never raise it.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    lock_q <= 1'b1;
      else if (wr_hit_i && !wr_bit_i) lock_q <= 1'b0;
   end

   assign lock_o = lock_q;

   assert_lock_never_rises_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$rose(lock_q));

   assert_lock_clears_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hit_i && !wr_bit_i) |=> !lock_q);

endmodule

// File: rtl/swrst_ctrl_cell.sv
module swrst_ctrl_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lock_i,
   input  logic wr_hit_i,
   input  logic wr_bit_i,
   output logic ctrl_o
);

   logic ctrl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 ctrl_q <= 1'b1;
      else if (wr_hit_i && lock_i) ctrl_q <= wr_bit_i;
   end

   assign ctrl_o = ctrl_q;

   assert_locked_ctrl_stable_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_i |=> $stable(ctrl_q));

   assert_open_write_lands_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hit_i && lock_i) |=> (ctrl_q == $past(wr_bit_i)));

endmodule

// File: rtl/swrst_read_mux.sv
module swrst_read_mux #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 32
) (
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [NUM_LINES-1:0] lock_i,
   input  logic [NUM_LINES-1:0] ctrl_i,
   output logic [DATA_W-1:0]    word_o
);

   always_comb begin
      word_o = '0;
      for (int unsigned i = 0; i < NUM_LINES; i++) begin
         if (int'(addr_i) == int'(i))             word_o[0] = lock_i[i];
         if (int'(addr_i) == int'(NUM_LINES + i)) word_o[0] = ctrl_i[i];
      end
   end

endmodule

// File: rtl/swrst_bank.sv
module swrst_bank
   import swrst_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 32,
   parameter bit          READ_REG  = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 wr_en_i,
   input  logic [DATA_W-1:0]    wr_data_i,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic [NUM_LINES-1:0] rst_hold_no
);

   localparam int unsigned USED_WORDS = 2 * NUM_LINES;
   localparam int unsigned ADDR_SPAN  = 1 << ADDR_W;

   initial begin
      assert (NUM_LINES >= 1) else $fatal(1, "NUM_LINES must be at least 1");
      assert (USED_WORDS <= ADDR_SPAN) else $fatal(1, "ADDR_W too narrow for the bank");
      assert (DATA_W >= 1) else $fatal(1, "DATA_W must be at least 1");
   end

   logic [NUM_LINES-1:0] lock_vec;
   logic [NUM_LINES-1:0] ctrl_vec;
   logic [DATA_W-1:0]    rd_word;
   logic                 unused_wdata;
   region_e              region;

   assign unused_wdata = ^wr_data_i;
   assign region       = region_of(int'(addr_i), NUM_LINES);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic lock_hit;
      logic ctrl_hit;

      assign lock_hit = wr_en_i && (int'(addr_i) == i);
      assign ctrl_hit = wr_en_i && (int'(addr_i) == NUM_LINES + i);

      swrst_lock_cell i_lock (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .wr_hit_i (lock_hit),
         .wr_bit_i (wr_data_i[0]),
         .lock_o   (lock_vec[i])
      );

      swrst_ctrl_cell i_ctrl (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .lock_i   (lock_vec[i]),
         .wr_hit_i (ctrl_hit),
         .wr_bit_i (wr_data_i[0]),
         .ctrl_o   (ctrl_vec[i])
      );
   end

   assign rst_hold_no = ctrl_vec;

   swrst_read_mux #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W)
   ) i_read_mux (
      .addr_i (addr_i),
      .lock_i (lock_vec),
      .ctrl_i (ctrl_vec),
      .word_o (rd_word)
   );

   if (READ_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rd_q <= '0;
         else         rd_q <= rd_word;
      end
      assign rd_data_o = rd_q;

      assert_unmapped_reads_zero_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (region == REG_NONE) |=> (rd_data_o == '0));
   end else begin : g_rd_comb
      assign rd_data_o = rd_word;

      assert_unmapped_reads_zero_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (region == REG_NONE) |-> (rd_data_o == '0));
   end

   if (DATA_W > 1) begin : g_upper_chk
      assert_upper_bits_zero_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         rd_data_o[DATA_W-1:1] == '0);
   end

   assert_unmapped_write_inert_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && region == REG_NONE) |=> ($stable(lock_vec) && $stable(ctrl_vec)));

endmodule

// File: tb/test_swrst_bank.sv
module test_swrst_bank;

   localparam int N  = 8;
   localparam int AW = 5;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [N-1:0]  rst_hold_n;

   int total = 0;
   int bad   = 0;

   bit lock_m [N];
   bit ctrl_m [N];

   always #10 clk = ~clk;

   swrst_bank #(.NUM_LINES(N), .ADDR_W(AW), .DATA_W(DW), .READ_REG(1'b0)) i_swrst_bank (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .addr_i      (addr),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .rd_data_o   (rd_data),
      .rst_hold_no (rst_hold_n)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] model_read(input int a);
      logic [DW-1:0] w = '0;
      if (a < N)          w[0] = lock_m[a];
      else if (a < 2 * N) w[0] = ctrl_m[a - N];
      return w;
   endfunction

   function automatic logic [DW-1:0] model_lines();
      logic [DW-1:0] v = '0;
      for (int i = 0; i < N; i++) v[i] = ctrl_m[i];
      return v;
   endfunction

   function automatic string read_tag(input int a);
      if (a >= 2 * N) return "R8";
      return "R7";
   endfunction

   // One clock: drive at negedge, compare against the model, advance model at posedge.
   task automatic step(input int a, input logic we, input logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wr_en = we; wr_data = d;
      #1;
      check(read_tag(a), rd_data, model_read(a));
      check("R2", DW'(rst_hold_n), model_lines());
      @(posedge clk);
      if (we) begin
         if (a < N) begin
            if (!d[0]) lock_m[a] = 1'b0;
         end else if (a < 2 * N) begin
            if (lock_m[a - N]) ctrl_m[a - N] = d[0];
         end
      end
   endtask

   task automatic peek(input int a, input string tag, input logic [DW-1:0] exp);
      @(negedge clk);
      addr = AW'(a); wr_en = 1'b0; wr_data = '0;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < N; i++) begin lock_m[i] = 1'b1; ctrl_m[i] = 1'b1; end
      repeat (2) @(negedge clk);
      check("R1", DW'(rst_hold_n), DW'({N{1'b1}}));
      @(negedge clk); rst_n = 1'b1;
      check("R1", DW'(rst_hold_n), DW'({N{1'b1}}));
      for (int a = 0; a < 2 * N; a++) peek(a, "R1", 32'h1);

      // R2 / R3: hold line 2 in reset, then release it
      step(N + 2, 1'b1, 32'h0);
      peek(0, "R2", 32'h1);
      check("R2", DW'(rst_hold_n), 32'hFB);
      step(N + 2, 1'b1, 32'h1);
      peek(N + 2, "R3", 32'h1);
      check("R3", DW'(rst_hold_n), 32'hFF);

      // R5: writing 1 to a lock is ignored; R4: clearing with bit0=0
      step(3, 1'b1, 32'hFFFF_FFFF);
      peek(3, "R5", 32'h1);
      step(3, 1'b1, 32'hFFFF_FFFE);
      peek(3, "R4", 32'h0);

      // R6: locked control ignores writes; R9: neighbour stays writable
      step(N + 3, 1'b1, 32'h0);
      peek(N + 3, "R6", 32'h1);
      step(N + 4, 1'b1, 32'h0);
      peek(N + 4, "R9", 32'h0);
      check("R9", DW'(rst_hold_n), 32'hEF);

      // R6: a line locked while low stays in reset
      step(N + 5, 1'b1, 32'h0);
      step(5, 1'b1, 32'h0);
      step(N + 5, 1'b1, 32'h1);
      check("R6", DW'(rst_hold_n), 32'hCF);

      // R5: a cleared lock cannot be set again
      step(3, 1'b1, 32'h1);
      peek(3, "R5", 32'h0);

      // R8: unmapped writes and reads
      step(2 * N, 1'b1, 32'h0);
      step(31, 1'b1, 32'h0);
      peek(2 * N, "R8", 32'h0);
      peek(31, "R8", 32'h0);
      check("R8", DW'(rst_hold_n), 32'hCF);
      for (int a = 0; a < N; a++) peek(a, "R8", model_read(a));

      // R7: only bit 0 of write data matters, upper read bits are zero
      step(N + 6, 1'b1, 32'hFFFF_FFFE);
      peek(N + 6, "R7", 32'h0);
      step(N + 6, 1'b1, 32'h0000_0001);
      peek(N + 6, "R7", 32'h1);

      // Random traffic against the model
      for (int k = 0; k < 400; k++) begin
         step(int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
              (($urandom_range(0, 7) == 0) ? 32'h0 : 32'($urandom)));
      end

      // R1: block reset restores everything, including cleared locks
      @(negedge clk); rst_n = 1'b0;
      for (int i = 0; i < N; i++) begin lock_m[i] = 1'b1; ctrl_m[i] = 1'b1; end
      #1;
      check("R1", DW'(rst_hold_n), DW'({N{1'b1}}));
      @(negedge clk); rst_n = 1'b1;
      for (int a = 0; a < 2 * N; a++) peek(a, "R1", 32'h1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule